// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Controller

This block is the coherence directory of one home node. It keeps one entry for every memory line homed at the node: a presence vector with one bit per cluster (a set bit means that cluster holds a read copy, an all-zero vector means nobody caches the line), an exclusive flag and the identity of the exclusive owner. Requests arrive as messages over a valid/ready port, each carrying a cluster identifier, a line index and a read/write flag. The controller answers with a grant message once the line is in a state that allows the access.

A write may only be granted to a single holder. Before a write grant, the controller sends one invalidate message per cycle to every other cluster whose bit is set, lowest cluster index first, and waits until one acknowledgement per invalidate has come back. A read of a line that another cluster holds exclusively first sends a fetch/downgrade message to that owner; after its acknowledgement the owner and the requester are both recorded as sharers and the exclusive flag is cleared. Only one transaction is in flight at a time, so a second request, whatever its line, waits with ready low.

The controller is a five-state machine. ST_IDLE accepts a request (IDLE to LOOK). ST_LOOK reads the entry and computes the probe set and the next entry; it moves to ST_PROBE when probes are needed and to ST_GRANT otherwise. ST_PROBE issues one probe per accepted cycle and moves to ST_WAIT after the last one. ST_WAIT moves to ST_GRANT when no acknowledgement is outstanding. ST_GRANT holds the response until it is taken, writes the entry back and returns to ST_IDLE.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every entry has an all-zero presence vector and a clear exclusive flag, req_ready is 1, and prb_valid and rsp_valid are 0.
- R2: A read of a line that is not exclusively held by another cluster sends no probe and is granted with the requester's bit added to the presence vector; the exclusive flag stays clear.
- R3: A write sends an invalidate (prb_kind 0) to every cluster whose presence bit is set except the requester, one per accepted probe cycle, in ascending cluster index, and to no other cluster.
- R4: A write is granted only after one acknowledgement has been counted for every probe sent; an acknowledgement with none outstanding is ignored. After the grant the presence vector holds only the requester's bit (bit number = cluster id) and the line is exclusive to it.
- R5: A read of a line held exclusively by another cluster sends exactly one fetch/downgrade (prb_kind 1) to the owner; the grant then shows owner and requester bits set and the line is no longer exclusive.
- R6: A read or write from the cluster that already owns the line exclusively sends no probe and leaves the entry unchanged.
- R7: req_ready is 1 only in ST_IDLE: from acceptance until the response is taken, no further request is accepted.
- R8: rsp_valid, once high, stays high with stable contents until rsp_ready; the response carries the requester id, the line, the write flag and the presence vector after the transaction.
- R9: The entries of different lines are independent: a transaction on one line neither probes for nor changes another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when both high |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_src | input | CID_W (4) | Requesting cluster |
| req_line | input | LINE_W (4) | Line index |
| prb_valid | output | 1 | Probe message present |
| prb_ready | input | 1 | Network takes the probe |
| prb_kind | output | 1 | 0 = invalidate, 1 = fetch/downgrade |
| prb_dst | output | CID_W (4) | Target cluster of the probe |
| ack_valid | input | 1 | One probe acknowledgement |
| rsp_valid | output | 1 | Grant message present |
| rsp_ready | input | 1 | Network takes the grant |
| rsp_write | output | 1 | Grant is for a write |
| rsp_dst | output | CID_W (4) | Cluster the grant goes to |
| rsp_line | output | LINE_W (4) | Line the grant is for |
| rsp_sharers | output | N_CL (16) | Presence vector after the transaction |

## Verification
The embedded assertions watch, on every cycle, that ready is never high while a probe or grant is pending, that probes and grants stay stable under back-pressure, that a grant never appears with acknowledgements still outstanding, and that an exclusive entry is written back with exactly one presence bit. Which clusters receive probes, in what order and of which kind, and what vector each line holds after a sequence of reads and writes, are only visible through the bench's scenarios: a sharing build-up followed by a write, owner downgrade, owner re-access, traffic on a second line, stray acknowledgements, back-pressure on both outgoing ports, and the cleared state after a second reset.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PROBE,
        ST_WAIT,
        ST_GRANT
    } dir_state_t;

    localparam logic PK_INV   = 1'b0;
    localparam logic PK_FETCH = 1'b1;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
    parameter int N_CL  = 16,
    parameter int LINES = 16,
    localparam int CID_W  = $clog2(N_CL),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_line,
    output logic [N_CL-1:0]   rd_pres,
    output logic              rd_excl,
    output logic [CID_W-1:0]  rd_own,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [N_CL-1:0]   wr_pres,
    input  logic              wr_excl,
    input  logic [CID_W-1:0]  wr_own
);
    logic [N_CL-1:0]  pres_a [LINES];
    logic             excl_a [LINES];
    logic [CID_W-1:0] own_a  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [N_CL-1:0]  p_r;
        logic             x_r;
        logic [CID_W-1:0] o_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                p_r <= '0;
                x_r <= 1'b0;
                o_r <= '0;
            end else if (wr_en && wr_line == LINE_W'(g)) begin
                p_r <= wr_pres;
                x_r <= wr_excl;
                o_r <= wr_own;
            end
        end

        assign pres_a[g] = p_r;
        assign excl_a[g] = x_r;
        assign own_a[g]  = o_r;
    end

    assign rd_pres = pres_a[rd_line];
    assign rd_excl = excl_a[rd_line];
    assign rd_own  = own_a[rd_line];

    // R4: an exclusive entry names exactly one holder
    p_excl_single_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_excl) |-> ($countones(wr_pres) == 1));
endmodule

// File: rtl/low_pick.sv
module low_pick #(
    parameter int N_CL = 16,
    localparam int CID_W = $clog2(N_CL)
) (
    input  logic [N_CL-1:0]  vec,
    output logic             any,
    output logic [CID_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_CL - 1; i >= 0; i--) begin
            if (vec[i]) idx = CID_W'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/ack_tally.sv
module ack_tally #(
    parameter int N_CL = 16,
    localparam int CW = $clog2(N_CL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sent,
    input  logic          ack,
    output logic [CW-1:0] pend,
    output logic          none
);
    logic take;
    assign take = ack && (pend != '0 || sent);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + CW'(sent) - CW'(take);
    end
    assign none = (pend == '0);
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int N_CL  = 16,
    parameter int LINES = 16,
    localparam int CID_W  = $clog2(N_CL),
    localparam int LINE_W = $clog2(LINES),
    localparam int CW     = $clog2(N_CL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CID_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    output logic              prb_valid,
    input  logic              prb_ready,
    output logic              prb_kind,
    output logic [CID_W-1:0]  prb_dst,
    input  logic              ack_valid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_write,
    output logic [CID_W-1:0]  rsp_dst,
    output logic [LINE_W-1:0] rsp_line,
    output logic [N_CL-1:0]   rsp_sharers
);
    localparam logic [N_CL-1:0] ONE = N_CL'(1);

    dir_state_t state_q, state_d;

    logic              t_wr;
    logic [CID_W-1:0]  t_src;
    logic [LINE_W-1:0] t_line;
    logic [N_CL-1:0]   mask_q, mask_d;
    logic              kind_q, kind_d;
    logic [N_CL-1:0]   np_q, np_d;
    logic              nx_q, nx_d;
    logic [CID_W-1:0]  no_q, no_d;

    logic [N_CL-1:0]   rd_pres;
    logic              rd_excl;
    logic [CID_W-1:0]  rd_own;
    logic [N_CL-1:0]   reqbit;
    logic              pick_any;
    logic [CID_W-1:0]  pick_idx;
    logic [N_CL-1:0]   mask_left;
    logic              prb_fire, acc, wr_en;
    logic [CW-1:0]     pend;
    logic              none_pend;

    dir_store #(.N_CL(N_CL), .LINES(LINES)) u_store (
        .clk(clk), .rst(rst),
        .rd_line(t_line), .rd_pres(rd_pres), .rd_excl(rd_excl), .rd_own(rd_own),
        .wr_en(wr_en), .wr_line(t_line), .wr_pres(np_q), .wr_excl(nx_q), .wr_own(no_q)
    );

    low_pick #(.N_CL(N_CL)) u_pick (
        .vec(mask_q), .any(pick_any), .idx(pick_idx)
    );

    ack_tally #(.N_CL(N_CL)) u_tally (
        .clk(clk), .rst(rst), .sent(prb_fire), .ack(ack_valid),
        .pend(pend), .none(none_pend)
    );

    assign reqbit    = ONE << t_src;
    assign mask_left = mask_q & ~(ONE << pick_idx);
    assign acc       = req_valid && req_ready;
    assign prb_fire  = prb_valid && prb_ready;
    assign wr_en     = rsp_valid && rsp_ready;

    // entry decision, evaluated in ST_LOOK
    always_comb begin
        mask_d = '0;
        kind_d = PK_INV;
        np_d   = rd_pres | reqbit;
        nx_d   = 1'b0;
        no_d   = rd_own;
        if (t_wr) begin
            mask_d = rd_pres & ~reqbit;
            np_d   = reqbit;
            nx_d   = 1'b1;
            no_d   = t_src;
        end else if (rd_excl && rd_own != t_src) begin
            mask_d = rd_pres;
            kind_d = PK_FETCH;
        end else if (rd_excl) begin
            np_d = rd_pres;
            nx_d = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transaction registers
    always_ff @(posedge clk) begin
        if (rst) begin
            t_wr <= 1'b0; t_src <= '0; t_line <= '0;
            mask_q <= '0; kind_q <= PK_INV;
            np_q <= '0; nx_q <= 1'b0; no_q <= '0;
        end else begin
            if (acc) begin
                t_wr <= req_write; t_src <= req_src; t_line <= req_line;
            end
            if (state_q == ST_LOOK) begin
                mask_q <= mask_d; kind_q <= kind_d;
                np_q <= np_d; nx_q <= nx_d; no_q <= no_d;
            end else if (prb_fire) begin
                mask_q <= mask_left;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        req_ready   = 1'b0;
        prb_valid   = 1'b0;
        rsp_valid   = 1'b0;
        prb_kind    = kind_q;
        prb_dst     = pick_idx;
        rsp_write   = t_wr;
        rsp_dst     = t_src;
        rsp_line    = t_line;
        rsp_sharers = np_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_LOOK;
            end
            ST_LOOK: begin
                state_d = (mask_d != '0) ? ST_PROBE : ST_GRANT;
            end
            ST_PROBE: begin
                prb_valid = pick_any;
                if (prb_ready && mask_left == '0) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (none_pend) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R7: no acceptance while a probe or grant is pending
    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!prb_valid && !rsp_valid));

    // R3: a stalled probe keeps its target and kind
    p_prb_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && !prb_ready) |=> (prb_valid && $stable(prb_dst) && $stable(prb_kind)));

    // R8: a stalled grant keeps its contents
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_sharers) && $stable(rsp_dst)));

    // R4: no grant while acknowledgements are outstanding
    p_grant_after_acks_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (pend == '0));
endmodule

// File: tb/sim_coh_dir_ctrl.sv
module sim_coh_dir_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_src = '0, req_line = '0;
    logic        req_ready;
    logic        prb_valid, prb_kind;
    logic        prb_ready = 1'b1;
    logic [3:0]  prb_dst;
    logic        ack_valid = 1'b0;
    logic        rsp_valid, rsp_write;
    logic        rsp_ready = 1'b0;
    logic [3:0]  rsp_dst, rsp_line;
    logic [15:0] rsp_sharers;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    coh_dir_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_src(req_src), .req_line(req_line),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind), .prb_dst(prb_dst),
        .ack_valid(ack_valid),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_write(rsp_write),
        .rsp_dst(rsp_dst), .rsp_line(rsp_line), .rsp_sharers(rsp_sharers)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  src;
        logic [3:0]  line;
        logic [15:0] mask;
        logic        kind;
        logic [15:0] shr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd2,  4'd3, 16'h0000, 1'b0, 16'h0004, 4'd2}, // R2 first reader
        '{1'b0, 4'd5,  4'd3, 16'h0000, 1'b0, 16'h0024, 4'd2}, // R2 second reader
        '{1'b0, 4'd9,  4'd3, 16'h0000, 1'b0, 16'h0224, 4'd2}, // R2 third reader
        '{1'b1, 4'd5,  4'd3, 16'h0204, 1'b0, 16'h0020, 4'd3}, // R3 invalidate 2 then 9
        '{1'b0, 4'd7,  4'd3, 16'h0020, 1'b1, 16'h00A0, 4'd5}, // R5 downgrade owner 5
        '{1'b1, 4'd0,  4'd3, 16'h00A0, 1'b0, 16'h0001, 4'd3}, // R3 invalidate 5 then 7
        '{1'b1, 4'd15, 4'd3, 16'h0001, 1'b0, 16'h8000, 4'd4}, // R4 take from owner 0
        '{1'b1, 4'd15, 4'd3, 16'h0000, 1'b0, 16'h8000, 4'd6}, // R6 owner rewrites
        '{1'b0, 4'd15, 4'd3, 16'h0000, 1'b0, 16'h8000, 4'd6}, // R6 owner reads
        '{1'b0, 4'd1,  4'd6, 16'h0000, 1'b0, 16'h0002, 4'd9}, // R9 other line
        '{1'b1, 4'd1,  4'd6, 16'h0000, 1'b0, 16'h0002, 4'd9}, // R9 sole sharer upgrades
        '{1'b0, 4'd3,  4'd3, 16'h8000, 1'b1, 16'h8008, 4'd5}  // R5 line 3 still owned by 15
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [3:0] src, input logic [3:0] line,
                           input logic [15:0] emask, input logic ekind, input logic [15:0] eshr,
                           input string rq, input int hold_prb, input int hold_rsp);
        logic [15:0] seen = '0;
        logic [15:0] held = '0;
        int  last = -1;
        int  cyc = 0;
        int  rw = 0;
        bit  done = 0;
        bit  fired = 0;
        bit  order_ok = 1;
        bit  kind_ok = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_src = src; req_line = line;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 200) begin
            ack_valid = fired;
            prb_ready = (cyc >= hold_prb);
            if (cyc == 0) chk(req_ready == 1'b0, "R7", "ready after accept", req_ready, 0);
            fired = prb_valid && prb_ready;
            if (prb_valid && prb_ready) begin
                if (int'(prb_dst) <= last) order_ok = 0;
                last = int'(prb_dst);
                seen[prb_dst] = 1'b1;
                if (prb_kind != ekind) kind_ok = 0;
            end
            if (rsp_valid) begin
                if (rw < hold_rsp) begin
                    if (rw == 0) held = rsp_sharers;
                    chk(req_ready == 1'b0, "R7", "ready while grant stalled", req_ready, 0);
                    chk(rsp_sharers == held, "R8", "stalled grant vector", rsp_sharers, held);
                    rsp_ready = 1'b0;
                    rw++;
                end else begin
                    chk(rsp_sharers == eshr, rq, "grant vector", rsp_sharers, eshr);
                    chk(rsp_dst == src && rsp_line == line && rsp_write == wr, "R8",
                        "grant fields", {rsp_write, rsp_dst, rsp_line}, {wr, src, line});
                    rsp_ready = 1'b1;
                    done = 1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        rsp_ready = 1'b0;
        ack_valid = 1'b0;
        prb_ready = 1'b1;
        if (!done) chk(1'b0, rq, "grant timeout", cyc, 0);
        chk(seen == emask, rq, "probe set", seen, emask);
        chk(order_ok, "R3", "probe order ascending", order_ok, 1);
        if (emask != '0) chk(kind_ok, rq, "probe kind", kind_ok, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(prb_valid == 1'b0 && rsp_valid == 1'b0, "R1", "idle outputs",
            {prb_valid, rsp_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i].wr, VEC[i].src, VEC[i].line, VEC[i].mask, VEC[i].kind,
                    VEC[i].shr, $sformatf("R%0d", VEC[i].rq), 0, 0);
        end

        // R7, R8: back-pressure on probes and grant during a write
        run_txn(1'b0, 4'd1, 4'd9, 16'h0000, 1'b0, 16'h0002, "R2", 0, 0);
        run_txn(1'b0, 4'd2, 4'd9, 16'h0000, 1'b0, 16'h0006, "R2", 0, 0);
        run_txn(1'b1, 4'd3, 4'd9, 16'h0006, 1'b0, 16'h0008, "R3", 3, 2);

        // R4: stray acknowledgements in idle are ignored
        @(negedge clk); ack_valid = 1'b1;
        repeat (2) @(negedge clk);
        ack_valid = 1'b0;
        run_txn(1'b0, 4'd6, 4'd9, 16'h0008, 1'b1, 16'h0048, "R5", 0, 0);

        // R1: a second reset clears every entry
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after second reset", req_ready, 1);
        run_txn(1'b0, 4'd4, 4'd3, 16'h0000, 1'b0, 16'h0010, "R1", 0, 0);
        run_txn(1'b0, 4'd4, 4'd9, 16'h0000, 1'b0, 16'h0010, "R1", 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule